// File: doc/BRIEF.md
# Manchester Run-Length Level Decoder

This block turns an already sliced, oversampled single-bit line into Manchester data bits. On each sample strobe it compares the new sample with the level held so far. It counts how many strobes a level lasts. When the level flips, the finished run is graded as a half-bit run, a whole-bit run or an out-of-range run. A small phase tracker then walks that stream of grades and decides which edges fall in the middle of a bit cell. It emits one data bit per mid-cell edge. Any run or pairing that a legal Manchester waveform cannot produce raises a one-cycle violation pulse.

The oversample ratio is a parameter (default 9 samples per bit). The run limits are derived from it as windows of plus or minus a quarter around the half-bit and full-bit lengths. A second parameter chooses whether a rising mid-cell edge means 1 or 0. A resync input makes the block forget both its run in progress and its bit phase. Packet framing and any checksum belong to a later stage.

Top module: `manchester_run_decoder`

## Requirements
- R1: While reset is held and in the first cycle after it is released, bitValid and violation are 0.
- R2: A run of length L (counted in strobes) is short when ceil(3*OVERSAMPLE/8) <= L <= floor(5*OVERSAMPLE/8). With the default this is 4 or 5.
- R3: A run is long when ceil(3*OVERSAMPLE/4) <= L <= floor(5*OVERSAMPLE/4). With the default this is 7 to 11.
- R4: A run that is neither short nor long (default: 1 to 3, 6, or 12 and above) produces violation = 1 for exactly one cycle. That cycle follows the clock edge whose strobe saw the level change.
- R5: The run counter stops at floor(5*OVERSAMPLE/4)+1 and never wraps. An idle level of any length is therefore reported as an out-of-range run when it finally ends.
- R6: The edge that ends a long run while phase is known or being hunted is a mid-cell edge. It yields bitValid = 1 in the cycle after that strobe, with bitData = 1 for a rising edge and 0 for a falling edge (default polarity). bitData holds its value while bitValid is 0.
- R7: After a mid-cell edge, a short run ends on a cell boundary and produces no bit. The next short run then ends on a mid-cell edge and produces a bit as in R6.
- R8: A long run that ends while the tracker sits on a cell boundary (one short run after a mid-cell edge) is a violation.
- R9: After any violation no bits are emitted until a long run ends. Short runs seen meanwhile produce neither a bit nor a violation.
- R10: When resync is 1, the following cycle carries no bit and no violation, even if a level change arrived in the same cycle. The first level change after it only starts a new run, so the run cut by resync is never graded.
- R11: The sample input is ignored in cycles where sampleStb is 0. Such cycles never lead to a bit or violation in the following cycle.
- R12: bitValid and violation are never 1 together. Each pulse appears only in the cycle right after a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleStb | input | 1 | Qualifies sampleIn for this cycle |
| sampleIn | input | 1 | Sliced line level |
| resync | input | 1 | Drop run in progress and bit phase |
| bitValid | output | 1 | One-cycle pulse: bitData carries a decoded bit |
| bitData | output | 1 | Decoded bit value, held between pulses |
| violation | output | 1 | One-cycle pulse: illegal run or run sequence |

## Verification
Some properties are checked on every cycle. The two output pulses never coincide, and each follows a strobe. Resync and strobe-less cycles leave the outputs quiet. bitData stays still between bits, and the run counter never passes its saturation value. Only the bench scenarios can show that a given run length is graded correctly at the edges of each window. The same holds for the order of the phase tracker: bits decoded from pairs of short runs, violations for a long run after a boundary, and phase regained on the first long run. Those scenarios also show that the run cut by resync is discarded.

// File: rtl/mrd_pkg.sv
package mrd_pkg;

  typedef enum logic [1:0] {
    RUN_INVALID = 2'd0,
    RUN_SHORT   = 2'd1,
    RUN_LONG    = 2'd2
  } runClass_e;

  // Datapath -> control: one completed run per pulse of done
  typedef struct packed {
    logic      done;
    runClass_e cls;
    logic      rising;   // direction of the edge that closed the run
  } runEvt_t;

  // Control -> datapath strobes
  typedef struct packed {
    logic restart;
  } ctrlStb_t;

  typedef enum logic [1:0] {
    PH_HUNT = 2'd0,   // bit phase unknown
    PH_MID  = 2'd1,   // last edge was mid-cell
    PH_EDGE = 2'd2    // last edge was on a cell boundary
  } phase_e;

endpackage

// File: rtl/mrd_run_counter.sv
module mrd_run_counter
  import mrd_pkg::*;
#(
  parameter int CNT_MAX = 12,
  parameter int CNT_W   = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleStb,
  input  logic             sampleIn,
  input  ctrlStb_t         ctrl,
  output logic             runDone,
  output logic             runRising,
  output logic [CNT_W-1:0] runLen
);

  localparam logic [CNT_W-1:0] SAT = CNT_W'(CNT_MAX);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             lastLevel;
  logic             haveEdge;
  logic [CNT_W-1:0] cntQ;
  logic             edgeSeen;

  assign edgeSeen  = sampleStb && (sampleIn != lastLevel);
  // a run is only complete if its start edge was seen too
  assign runDone   = edgeSeen && haveEdge && !ctrl.restart;
  assign runRising = sampleIn;
  assign runLen    = cntQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastLevel <= 1'b0;
      haveEdge  <= 1'b0;
      cntQ      <= '0;
    end else begin
      if (sampleStb) lastLevel <= sampleIn;
      if (ctrl.restart) begin
        haveEdge <= 1'b0;
        cntQ     <= '0;
      end else if (edgeSeen) begin
        haveEdge <= 1'b1;
        cntQ     <= ONE;
      end else if (sampleStb && haveEdge && (cntQ != SAT)) begin
        cntQ <= cntQ + ONE;
      end
    end
  end

endmodule

// File: rtl/mrd_run_classifier.sv
module mrd_run_classifier
  import mrd_pkg::*;
#(
  parameter int OVERSAMPLE = 9,
  parameter int CNT_W      = 4
) (
  input  logic [CNT_W-1:0] runLen,
  output runClass_e        cls
);

  // quarter-tolerance windows, computed in eighths to stay integral
  localparam int SHORT_MIN = (3 * OVERSAMPLE + 7) / 8;
  localparam int SHORT_MAX = (5 * OVERSAMPLE) / 8;
  localparam int LONG_MIN  = (3 * OVERSAMPLE + 3) / 4;
  localparam int LONG_MAX  = (5 * OVERSAMPLE) / 4;

  localparam logic [CNT_W-1:0] S_LO = CNT_W'(SHORT_MIN);
  localparam logic [CNT_W-1:0] S_HI = CNT_W'(SHORT_MAX);
  localparam logic [CNT_W-1:0] L_LO = CNT_W'(LONG_MIN);
  localparam logic [CNT_W-1:0] L_HI = CNT_W'(LONG_MAX);

  logic isShort;
  logic isLong;

  assign isShort = (runLen >= S_LO) && (runLen <= S_HI);
  assign isLong  = (runLen >= L_LO) && (runLen <= L_HI);

  always_comb begin
    if (isShort)     cls = RUN_SHORT;
    else if (isLong) cls = RUN_LONG;
    else             cls = RUN_INVALID;
  end

endmodule

// File: rtl/mrd_phase_ctrl.sv
module mrd_phase_ctrl
  import mrd_pkg::*;
#(
  parameter bit RISE_IS_ONE = 1'b1
) (
  input  logic     clk,
  input  logic     rstN,
  input  runEvt_t  evt,
  input  logic     resync,
  output ctrlStb_t ctrl,
  output logic     bitValid,
  output logic     bitData,
  output logic     violation
);

  phase_e phaseQ, phaseN;
  logic   emit;
  logic   viol;
  logic   edgeBit;

  assign ctrl.restart = resync;

  generate
    if (RISE_IS_ONE) begin : g_riseOne
      assign edgeBit = evt.rising;
    end else begin : g_riseZero
      assign edgeBit = !evt.rising;
    end
  endgenerate

  always_comb begin
    phaseN = phaseQ;
    emit   = 1'b0;
    viol   = 1'b0;
    if (resync) begin
      phaseN = PH_HUNT;
    end else if (evt.done) begin
      unique case (evt.cls)
        RUN_LONG: begin
          if (phaseQ == PH_EDGE) begin
            viol   = 1'b1;
            phaseN = PH_HUNT;
          end else begin
            emit   = 1'b1;
            phaseN = PH_MID;
          end
        end
        RUN_SHORT: begin
          unique case (phaseQ)
            PH_HUNT: phaseN = PH_HUNT;
            PH_MID:  phaseN = PH_EDGE;
            PH_EDGE: begin
              emit   = 1'b1;
              phaseN = PH_MID;
            end
            default: phaseN = PH_HUNT;
          endcase
        end
        default: begin
          viol   = 1'b1;
          phaseN = PH_HUNT;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseQ    <= PH_HUNT;
      bitValid  <= 1'b0;
      bitData   <= 1'b0;
      violation <= 1'b0;
    end else begin
      phaseQ    <= phaseN;
      bitValid  <= emit;
      violation <= viol;
      if (emit) bitData <= edgeBit;
    end
  end

endmodule

// File: rtl/manchester_run_decoder.sv
module manchester_run_decoder
  import mrd_pkg::*;
#(
  parameter int OVERSAMPLE  = 9,
  parameter bit RISE_IS_ONE = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic sampleStb,
  input  logic sampleIn,
  input  logic resync,
  output logic bitValid,
  output logic bitData,
  output logic violation
);

  localparam int LONG_MAX = (5 * OVERSAMPLE) / 4;
  localparam int CNT_MAX  = LONG_MAX + 1;
  localparam int CNT_W    = $clog2(CNT_MAX + 1);

  ctrlStb_t         ctrl;
  runEvt_t          evt;
  logic             runDone;
  logic             runRising;
  logic [CNT_W-1:0] runLen;
  runClass_e        runCls;

  mrd_run_counter #(
    .CNT_MAX(CNT_MAX),
    .CNT_W  (CNT_W)
  ) i_runCounter (
    .clk      (clk),
    .rstN     (rstN),
    .sampleStb(sampleStb),
    .sampleIn (sampleIn),
    .ctrl     (ctrl),
    .runDone  (runDone),
    .runRising(runRising),
    .runLen   (runLen)
  );

  mrd_run_classifier #(
    .OVERSAMPLE(OVERSAMPLE),
    .CNT_W     (CNT_W)
  ) i_runClassifier (
    .runLen(runLen),
    .cls   (runCls)
  );

  assign evt.done   = runDone;
  assign evt.cls    = runCls;
  assign evt.rising = runRising;

  mrd_phase_ctrl #(
    .RISE_IS_ONE(RISE_IS_ONE)
  ) i_phaseCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .evt      (evt),
    .resync   (resync),
    .ctrl     (ctrl),
    .bitValid (bitValid),
    .bitData  (bitData),
    .violation(violation)
  );

endmodule

// File: rtl/mrd_checker.sv
module mrd_checker #(
  parameter int CNT_W   = 4,
  parameter int CNT_MAX = 12
) (
  input logic             clk,
  input logic             rstN,
  input logic             sampleStb,
  input logic             resync,
  input logic             bitValid,
  input logic             bitData,
  input logic             violation,
  input logic [CNT_W-1:0] runLen
);

  assert_pulse_exclusive_R12: assert property (@(posedge clk) disable iff (!rstN)
    !(bitValid && violation));

  assert_bit_after_strobe_R12: assert property (@(posedge clk) disable iff (!rstN)
    bitValid |-> $past(sampleStb));

  assert_viol_after_strobe_R4: assert property (@(posedge clk) disable iff (!rstN)
    violation |-> $past(sampleStb));

  assert_resync_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    resync |=> (!bitValid && !violation));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    !sampleStb |=> (!bitValid && !violation));

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rstN)
    int'(runLen) <= CNT_MAX);

  assert_data_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !bitValid |-> $stable(bitData));

endmodule

bind manchester_run_decoder mrd_checker #(
  .CNT_W  (CNT_W),
  .CNT_MAX(CNT_MAX)
) i_mrdChecker (
  .clk      (clk),
  .rstN     (rstN),
  .sampleStb(sampleStb),
  .resync   (resync),
  .bitValid (bitValid),
  .bitData  (bitData),
  .violation(violation),
  .runLen   (runLen)
);

// File: tb/test_manchester_run_decoder.sv
module test_manchester_run_decoder;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleStb = 1'b0;
  logic sampleIn = 1'b0;
  logic resync = 1'b0;
  logic bitValid, bitData, violation;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  manchester_run_decoder i_manchester_run_decoder (
    .clk      (clk),
    .rstN     (rstN),
    .sampleStb(sampleStb),
    .sampleIn (sampleIn),
    .resync   (resync),
    .bitValid (bitValid),
    .bitData  (bitData),
    .violation(violation)
  );

  // {level, run length, requirement number, expV, expD, expX}
  // expectations refer to the first sample of the run (end of previous run)
  localparam int NV = 24;
  localparam logic [13:0] VEC [NV] = '{
    {1'b0, 6'd5,  4'd1,  3'b000},  // R1 no edge yet
    {1'b1, 6'd9,  4'd10, 3'b000},  // first edge only starts a run
    {1'b0, 6'd9,  4'd6,  3'b100},  // R6 long, falling -> 0
    {1'b1, 6'd9,  4'd6,  3'b110},  // R6 long, rising -> 1
    {1'b0, 6'd4,  4'd6,  3'b100},  // long -> 0
    {1'b1, 6'd5,  4'd7,  3'b000},  // R7 short(4) -> boundary
    {1'b0, 6'd9,  4'd7,  3'b100},  // R7 short(5) paired, falling -> 0
    {1'b1, 6'd5,  4'd3,  3'b110},  // R3 long 9 rising -> 1
    {1'b0, 6'd4,  4'd2,  3'b000},  // R2 short 5 -> boundary
    {1'b1, 6'd7,  4'd2,  3'b110},  // R2 short 4 paired, rising -> 1
    {1'b0, 6'd11, 4'd3,  3'b100},  // R3 long 7 lower bound
    {1'b1, 6'd4,  4'd3,  3'b110},  // R3 long 11 upper bound
    {1'b0, 6'd9,  4'd7,  3'b000},  // short 4 -> boundary
    {1'b1, 6'd3,  4'd8,  3'b001},  // R8 long after boundary
    {1'b0, 6'd5,  4'd4,  3'b001},  // R4 run of 3
    {1'b1, 6'd4,  4'd9,  3'b000},  // R9 short while hunting
    {1'b0, 6'd6,  4'd9,  3'b000},  // R9 short while hunting
    {1'b1, 6'd9,  4'd4,  3'b001},  // R4 run of 6
    {1'b0, 6'd12, 4'd9,  3'b100},  // R9 long regains phase, falling -> 0
    {1'b1, 6'd9,  4'd4,  3'b001},  // R4 run of 12
    {1'b0, 6'd9,  4'd9,  3'b100},  // long 9 -> 0
    {1'b1, 6'd40, 4'd6,  3'b110},  // long 9 -> 1
    {1'b0, 6'd9,  4'd5,  3'b001},  // R5 saturated idle run -> violation
    {1'b1, 6'd9,  4'd9,  3'b110}   // long -> 1
  };

  task automatic checkOut(input logic expV, input logic expD, input logic expX,
                          input int req);
    nChecks++;
    if (bitValid !== expV || violation !== expX || (expV && bitData !== expD)) begin
      nFails++;
      $display("FAIL R%0d: valid/data/viol = %b/%b/%b expected %b/%b/%b",
               req, bitValid, bitData, violation, expV, expD, expX);
    end
  endtask

  // called at a negedge; returns at a negedge
  task automatic doSample(input logic lvl, input logic rs, input logic expV,
                          input logic expD, input logic expX, input int req);
    sampleStb = 1'b1;
    sampleIn  = lvl;
    resync    = rs;
    @(negedge clk);
    checkOut(expV, expD, expX, req);
    // strobe-less cycle with the opposite level: must be ignored (R11)
    sampleStb = 1'b0;
    sampleIn  = ~lvl;
    resync    = 1'b0;
    @(negedge clk);
    checkOut(1'b0, 1'b0, 1'b0, 11);
    sampleIn  = lvl;
  endtask

  task automatic sendRun(input logic lvl, input int len, input logic expV,
                         input logic expD, input logic expX, input int req);
    doSample(lvl, 1'b0, expV, expD, expX, req);
    for (int k = 1; k < len; k++) doSample(lvl, 1'b0, 1'b0, 1'b0, 1'b0, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    checkOut(1'b0, 1'b0, 1'b0, 1);
    rstN = 1'b1;
    @(negedge clk);
    checkOut(1'b0, 1'b0, 1'b0, 1);

    for (int i = 0; i < NV; i++) begin
      sendRun(VEC[i][13], int'(VEC[i][12:7]), VEC[i][2], VEC[i][1], VEC[i][0],
              int'(VEC[i][6:3]));
    end

    // R10: resync together with a level change that would give a bit
    doSample(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 10);
    for (int k = 1; k < 9; k++) doSample(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 10);
    // first edge after resync only starts counting (R10)
    sendRun(1'b1, 9, 1'b0, 1'b0, 1'b0, 10);
    // long run then decodes from hunt, falling -> 0 (R6, R9)
    sendRun(1'b0, 9, 1'b1, 1'b0, 1'b0, 6);
    // lone resync pulse without strobe keeps outputs quiet
    resync = 1'b1;
    @(negedge clk);
    resync = 1'b0;
    checkOut(1'b0, 1'b0, 1'b0, 10);
    // phase was dropped: a short run produces nothing, then long regains
    sendRun(1'b1, 4, 1'b0, 1'b0, 1'b0, 10);
    sendRun(1'b0, 9, 1'b0, 1'b0, 1'b0, 9);
    sendRun(1'b1, 9, 1'b1, 1'b1, 1'b0, 9);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule